// File: doc/BRIEF.md
# Ratio-Tracking Clock Divider with Non-Overlapping Pulse Phases

This block takes a fixed master clock and produces a slow clock whose period is a programmable whole number of master cycles. In the low half of each slow-clock period it also produces two pulses, A and B, one after the other. The slow clock and both pulses never overlap. One period counter runs on the master clock. Every output edge comes from comparing that counter against thresholds derived from the active ratio. A new ratio therefore changes the pulse widths in proportion to the new period, with no other adjustment.

The ratio word can be rewritten at any time. It is sampled only when the counter wraps, so a period in progress always completes with the ratio it started with. All three outputs come straight from flip-flops in the master-clock domain.

Phases in the requirements below count master cycles within one slow-clock period. Phase 0 is the first master cycle in which the slow clock is low. N is the effective ratio.

Top module: `ratio_phase_div`

## Requirements
- R1: While reset is asserted, and in the first master cycle after it is released, all three outputs are low. That first cycle is phase 0 of a period whose ratio is the effective value of the ratio word during reset.
- R2: Each slow-clock period lasts exactly N master cycles. The interval between successive falling edges of the slow clock equals the N of the period that just ended.
- R3: The slow clock is low for phases 0 to floor(N/2)-1 and high for phases floor(N/2) to N-1. It falls at phase 0 and rises at phase floor(N/2).
- R4: Pulse A is high exactly in phases 1 to floor(N/4)-2. For N=100 it rises at phase 1 and falls at phase 24.
- R5: Pulse B is high exactly in phases floor(N/4) to floor(N/2)-2. For N=100 it rises at phase 25 and falls at phase 49.
- R6: No two of the slow clock, A and B are ever high in the same master cycle. At least one all-low cycle separates A falling from B rising, and B falling from the slow clock rising.
- R7: A ratio word below 100, including 0, is treated as N=100.
- R8: The ratio word is sampled only at the master edge that ends phase N-1. Changes at any other time do not alter the current period. If the word changes several times within one period, the value present at the wrap is the one used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m_i | input | 1 | Fixed master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_i | input | W (16) | Requested division ratio, sampled at period wrap |
| slow_clk_o | output | 1 | Divided clock |
| pulse_a_o | output | 1 | First pulse in the slow-clock low half |
| pulse_b_o | output | 1 | Second pulse in the slow-clock low half |

## Verification
The checker watches every cycle for the mutual exclusion of the three outputs, for the idle gaps before B rises and before the slow clock rises, and for A starting one cycle after the slow clock falls. It also checks that the counter stays below the active period, that the period register changes only at a wrap, and that the period never drops under 100. Only the bench's scenarios can show the exact edge phases for odd and even ratios, the measured period lengths, and the clamping of small ratio words. The same holds for the ratio staying unchanged across mid-period rewrites and for the restart after a second reset.

// File: rtl/ratio_phase_pkg.sv
package ratio_phase_pkg;

  typedef struct packed {
    logic slow;
    logic a;
    logic b;
  } phase_t;

  // Effective period: small requests are lifted to the floor value
  function automatic int unsigned eff_ratio(int unsigned req, int unsigned floor_val);
    return (req < floor_val) ? floor_val : req;
  endfunction

  // First phase of the slow-clock high half
  function automatic int unsigned rise_at(int unsigned n);
    return n >> 1;
  endfunction

  // Last phase in which pulse A is high
  function automatic int unsigned a_last(int unsigned n);
    return (n >> 2) - 2;
  endfunction

  // First phase in which pulse B is high
  function automatic int unsigned b_first(int unsigned n);
    return n >> 2;
  endfunction

  // Last phase in which pulse B is high
  function automatic int unsigned b_last(int unsigned n);
    return (n >> 1) - 2;
  endfunction

endpackage

// File: rtl/rpd_period_ctr.sv
module rpd_period_ctr #(
  parameter int W         = 16,
  parameter int MIN_RATIO = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic [W-1:0] period_q,
  output logic [W-1:0] period_nxt,
  output logic         wrap
);
  import ratio_phase_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] eff;

  always_comb begin
    eff        = W'(eff_ratio(32'(ratio_i), 32'(MIN_RATIO)));
    wrap       = (cnt_q == period_q - ONE);
    cnt_nxt    = wrap ? '0 : cnt_q + ONE;
    period_nxt = wrap ? eff : period_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      period_q <= eff;
    end else begin
      cnt_q    <= cnt_nxt;
      period_q <= period_nxt;
    end
  end

endmodule

// File: rtl/rpd_phase_cmp.sv
module rpd_phase_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0]            cnt,
  input  logic [W-1:0]            period,
  output ratio_phase_pkg::phase_t ph
);
  import ratio_phase_pkg::*;

  int unsigned c;
  int unsigned n;

  always_comb begin
    c       = 32'(cnt);
    n       = 32'(period);
    ph.slow = (c >= rise_at(n));
    ph.a    = (c >= 1) && (c <= a_last(n));
    ph.b    = (c >= b_first(n)) && (c <= b_last(n));
  end

endmodule

// File: rtl/rpd_out_reg.sv
module rpd_out_reg #(
  parameter int NUM_OUT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] d,
  output logic [NUM_OUT-1:0] q
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end

endmodule

// File: rtl/ratio_phase_div.sv
module ratio_phase_div #(
  parameter int W         = 16,
  parameter int MIN_RATIO = 100
) (
  input  logic         clk_m_i,
  input  logic         rst_i,
  input  logic [W-1:0] ratio_i,
  output logic         slow_clk_o,
  output logic         pulse_a_o,
  output logic         pulse_b_o
);
  import ratio_phase_pkg::*;

  localparam int NUM_OUT = 3;

  logic [W-1:0]       cnt_q;
  logic [W-1:0]       cnt_nxt;
  logic [W-1:0]       period_q;
  logic [W-1:0]       period_nxt;
  logic               wrap_evt;
  phase_t             ph_nxt;
  logic [NUM_OUT-1:0] out_d;
  logic [NUM_OUT-1:0] out_q;

  rpd_period_ctr #(.W(W), .MIN_RATIO(MIN_RATIO)) u_ctr (
    .clk        (clk_m_i),
    .rst        (rst_i),
    .ratio_i    (ratio_i),
    .cnt_q      (cnt_q),
    .cnt_nxt    (cnt_nxt),
    .period_q   (period_q),
    .period_nxt (period_nxt),
    .wrap       (wrap_evt)
  );

  // Compare on the next count so the registered outputs line up with cnt_q
  rpd_phase_cmp #(.W(W)) u_cmp (
    .cnt    (cnt_nxt),
    .period (period_nxt),
    .ph     (ph_nxt)
  );

  assign out_d = {ph_nxt.slow, ph_nxt.a, ph_nxt.b};

  rpd_out_reg #(.NUM_OUT(NUM_OUT)) u_oreg (
    .clk (clk_m_i),
    .rst (rst_i),
    .d   (out_d),
    .q   (out_q)
  );

  assign slow_clk_o = out_q[2];
  assign pulse_a_o  = out_q[1];
  assign pulse_b_o  = out_q[0];

endmodule

// File: rtl/rpd_checker.sv
module rpd_checker #(
  parameter int W         = 16,
  parameter int MIN_RATIO = 100
) (
  input logic         clk,
  input logic         rst,
  input logic         slow,
  input logic         a,
  input logic         b,
  input logic         wrap,
  input logic [W-1:0] cnt,
  input logic [W-1:0] period
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    $countones({slow, a, b}) <= 1); // R6

  AST_GAP_A_TO_B: assert property (@(posedge clk) disable iff (rst)
    $rose(b) |-> !$past(a)); // R6

  AST_GAP_B_TO_CLK: assert property (@(posedge clk) disable iff (rst)
    $rose(slow) |-> !$past(b)); // R6

  AST_A_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(slow) |=> a); // R4

  AST_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (!slow && cnt == '0)); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < period); // R2

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (rst)
    32'(period) >= 32'(MIN_RATIO)); // R7

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(period)); // R8

endmodule

bind ratio_phase_div rpd_checker #(.W(W), .MIN_RATIO(MIN_RATIO)) u_rpd_chk (
  .clk    (clk_m_i),
  .rst    (rst_i),
  .slow   (slow_clk_o),
  .a      (pulse_a_o),
  .b      (pulse_b_o),
  .wrap   (wrap_evt),
  .cnt    (cnt_q),
  .period (period_q)
);

// File: tb/sim_ratio_phase_div.sv
module sim_ratio_phase_div;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int FLOOR_N    = 100;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ratio = W'(100);
  logic         s_o, a_o, b_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  int p, n, n_done, since_fall;
  int cnt_a, cnt_b, cnt_h;
  bit prev_s;

  ratio_phase_div #(.W(W), .MIN_RATIO(FLOOR_N)) u0 (
    .clk_m_i    (clk),
    .rst_i      (rst),
    .ratio_i    (ratio),
    .slow_clk_o (s_o),
    .pulse_a_o  (a_o),
    .pulse_b_o  (b_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lift(int r);
    if (r < FLOOR_N) return FLOOR_N;
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (phase %0d, N %0d)", req, act, exp, p, n);
    end
  endtask

  task automatic model_start();
    p = 0; n = lift(int'(ratio)); n_done = n;
    since_fall = 0; cnt_a = 0; cnt_b = 0; cnt_h = 0; prev_s = 0;
  endtask

  // compare the current outputs against the phase model
  task automatic check_now();
    bit es, ea, eb;
    es = (p >= n / 2);                       // R3
    ea = (p >= 1) && (p + 2 <= n / 4);       // R4
    eb = (p >= n / 4) && (p + 2 <= n / 2);   // R5
    check(s_o == es, "R3 slow clock level", int'(s_o), int'(es));
    check(a_o == ea, "R4 pulse A level", int'(a_o), int'(ea));
    check(b_o == eb, "R5 pulse B level", int'(b_o), int'(eb));
    check((int'(s_o) + int'(a_o) + int'(b_o)) <= 1, "R6 overlap",
          int'(s_o) + int'(a_o) + int'(b_o), 1);
    if (prev_s && !s_o) begin
      check(since_fall == n_done, "R2 fall-to-fall interval", since_fall, n_done);
      since_fall = 0;
    end
    since_fall++;
    prev_s = s_o;
    if (a_o) cnt_a++;
    if (b_o) cnt_b++;
    if (s_o) cnt_h++;
  endtask

  task automatic advance();
    if (p == n - 1) begin
      check(cnt_a == n / 4 - 2, "R4 A width", cnt_a, n / 4 - 2);
      check(cnt_b == n / 2 - 1 - n / 4, "R5 B width", cnt_b, n / 2 - 1 - n / 4);
      check(cnt_h == n - n / 2, "R3 high width", cnt_h, n - n / 2);
      cnt_a = 0; cnt_b = 0; cnt_h = 0;
      n_done = n;
      p = 0;
      n = lift(int'(ratio));   // R8: sampled only here
    end else begin
      p++;
    end
  endtask

  task automatic run_cycles(int k);
    for (int i = 0; i < k; i++) begin
      check_now();
      advance();
      @(negedge clk);
    end
  endtask

  task automatic go_ratio(int r, int periods);
    ratio = W'(r);
    run_cycles((n - p) + periods * lift(r));
  endtask

  task automatic do_reset(int r);
    rst   = 1'b1;
    ratio = W'(r);
    repeat (3) @(negedge clk);
    check(!s_o && !a_o && !b_o, "R1 outputs low in reset",
          int'({s_o, a_o, b_o}), 0);
    rst = 1'b0;
    model_start();
  endtask

  initial begin
    @(negedge clk);
    do_reset(100);
    check(!s_o && !a_o && !b_o, "R1 phase 0 after release", int'({s_o, a_o, b_o}), 0);
    run_cycles(300);                 // R2..R6 at N=100
    go_ratio(101, 2);
    go_ratio(102, 2);
    go_ratio(103, 2);
    go_ratio(99, 2);                 // R7 clamp
    check(n == 100, "R7 clamp of 99", n, 100);
    go_ratio(0, 2);                  // R7 clamp
    check(n == 100, "R7 clamp of 0", n, 100);
    go_ratio(137, 2);
    go_ratio(200, 2);
    // R8: rewrite mid-period, current period must keep its length
    run_cycles(40);
    ratio = W'(300);
    run_cycles(50);
    ratio = W'(500);
    run_cycles(10);
    ratio = W'(120);
    run_cycles((n - p) + 2 * 120);
    check(n == 120, "R8 last value before wrap used", n, 120);
    go_ratio(1001, 1);
    go_ratio(4099, 1);
    // R1: reset in mid-period with a new ratio
    run_cycles(700);
    do_reset(160);
    check(n == 160, "R1 ratio taken during reset", n, 160);
    run_cycles(3 * 160);
    go_ratio(100, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule